// File: doc/BRIEF.md
# Nibble-Wide Frequency-Word Write Port

This block is the target end of a fast serial write link. A host uses it to load a new 64-bit tuning word into a numerically controlled oscillator. The host pulls chip select low and toggles a serial clock. On each rising edge of that clock it presents one 4-bit nibble. The first four nibbles form a header. The header holds a direction flag and a 15-bit starting register address. Every later pair of nibbles forms one byte. Each byte is placed in a shadow register, and the register address then moves on by one on its own. A full 64-bit word therefore takes 4 + 8×2 = 20 serial clocks, and a 32-bit word takes 12.

The new word does not affect the oscillator while the transfer runs. When chip select goes high again, the system-clock side sees the rising edge through a two-flop synchroniser. If the transaction was a write, it copies all eight shadow bytes into the active frequency register in a single cycle and raises a one-cycle commit pulse. A phase accumulator adds the active word every system cycle, wrapping modulo 2^64. The top 16 bits of the phase form the output. The word is scaled so that a value of 2^63 corresponds to half the sample rate.

Top module: `fr_tune_port`

## Requirements
- R1: A transaction header is the first 4 nibbles after chip select falls. Bit 3 of the first nibble is the direction flag (0 = write, 1 = read). The remaining 15 header bits give the starting register address, most significant bit first.
- R2: Each byte after the header is sent as two nibbles, high nibble first. Register address k, for k from 0 to 7, holds bits [8k+7:8k] of the frequency word.
- R3: The register address goes up by one after every complete byte. A header followed by 8 bytes, 20 serial clocks in all, loads the whole 64-bit word.
- R4: A byte with only its high nibble received when chip select rises is discarded and changes no shadow register.
- R5: The active frequency word does not change while chip select is low. After chip select rises at the end of a write transaction, all eight shadow bytes enter the active word in one system cycle. The commit pulse is high for exactly that one cycle, and the new word shows on `freq_word` from the same cycle.
- R6: A read transaction writes no shadow register and produces no commit pulse.
- R7: A byte sent to an address of 8 or more is accepted and changes no state. Address incrementing carries on through such addresses.
- R8: On every system cycle the phase accumulator adds the active word, modulo 2^64. `phase_out` is phase bits [63:48].
- R9: After reset the active word is 0, `phase_out` is 0 and the commit pulse is low.
- R10: Shadow bytes keep their values between transactions. A write that loads only some bytes commits the new bytes together with the old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for commit logic and phase accumulator |
| sys_rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fr_sclk | input | 1 | Serial clock; data sampled on its rising edge |
| fr_cs_n | input | 1 | Active-low chip select framing a transaction |
| fr_data | input | 4 | Serial nibble bus |
| commit_pulse | output | 1 | One-cycle pulse when a new word becomes active |
| freq_word | output | 64 | Active frequency word |
| phase_out | output | 16 | Top bits of the phase accumulator |

## Verification
Some states can be seen at the ports only indirectly. One is a read transaction or a partial byte leaving the shadow bytes untouched. Another is a byte sent to an out-of-range address being dropped. Each such transaction is followed by a write that carries a header and few or no bytes. That write commits the untouched shadow contents, so the scoreboard can compare them against its own byte model. The phase wrap is reached by committing words that are whole multiples of 2^48, so that `phase_out` steps by an exact amount that can be predicted, up to 0xFFFF per cycle.

// File: rtl/fr_tune_pkg.sv
`timescale 1ns/1ps
package fr_tune_pkg;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HDR_NIBS  = 4;
  localparam int unsigned HDR_W     = NIB_W * HDR_NIBS;
  localparam int unsigned ADDR_W    = HDR_W - 1;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W;
  localparam int unsigned PHASE_OUT_W = 16;
endpackage

// File: rtl/fr_serial_rx.sv
`timescale 1ns/1ps
module fr_serial_rx #(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned HDR_NIBS = 4,
  localparam int unsigned HDR_W   = NIB_W * HDR_NIBS,
  localparam int unsigned ADDR_W  = HDR_W - 1,
  localparam int unsigned BYTE_W  = 2 * NIB_W,
  localparam int unsigned CNT_W   = $clog2(HDR_NIBS + 1)
) (
  input  logic              sclk,
  input  logic              xfer_rst_n,
  input  logic              arst_n,
  input  logic [NIB_W-1:0]  nib_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              txn_wr
);
  localparam logic [CNT_W-1:0] HDR_DONE = CNT_W'(HDR_NIBS);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_NIBS - 1);

  logic [CNT_W-1:0]  hdr_cnt_q, hdr_cnt_d;
  logic [HDR_W-1:0]  hdr_sr_q,  hdr_sr_d;
  logic [ADDR_W-1:0] addr_q,    addr_d;
  logic [NIB_W-1:0]  hi_q,      hi_d;
  logic              half_q,    half_d;
  logic              txn_wr_d;

  always_comb begin
    hdr_cnt_d = hdr_cnt_q;
    hdr_sr_d  = hdr_sr_q;
    addr_d    = addr_q;
    hi_d      = hi_q;
    half_d    = half_q;
    txn_wr_d  = txn_wr;
    wr_en     = 1'b0;
    wr_addr   = addr_q;
    wr_byte   = {hi_q, nib_in};
    if (hdr_cnt_q != HDR_DONE) begin
      hdr_sr_d  = {hdr_sr_q[HDR_W-NIB_W-1:0], nib_in};
      hdr_cnt_d = hdr_cnt_q + 1'b1;
      if (hdr_cnt_q == '0) begin
        txn_wr_d = 1'b0;
      end
      if (hdr_cnt_q == HDR_LAST) begin
        addr_d   = hdr_sr_d[ADDR_W-1:0];
        txn_wr_d = ~hdr_sr_d[HDR_W-1];
      end
    end else if (!half_q) begin
      hi_d   = nib_in;
      half_d = 1'b1;
    end else begin
      half_d = 1'b0;
      wr_en  = txn_wr;
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge xfer_rst_n) begin
    if (!xfer_rst_n) begin
      hdr_cnt_q <= '0;
      hdr_sr_q  <= '0;
      addr_q    <= '0;
      hi_q      <= '0;
      half_q    <= 1'b0;
    end else begin
      hdr_cnt_q <= hdr_cnt_d;
      hdr_sr_q  <= hdr_sr_d;
      addr_q    <= addr_d;
      hi_q      <= hi_d;
      half_q    <= half_d;
    end
  end

  always_ff @(posedge sclk or negedge arst_n) begin
    if (!arst_n) begin
      txn_wr <= 1'b0;
    end else begin
      txn_wr <= txn_wr_d;
    end
  end
endmodule

// File: rtl/fr_shadow_bank.sv
`timescale 1ns/1ps
module fr_shadow_bank #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES
) (
  input  logic              sclk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [WORD_W-1:0] shadow_word
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_byte
    logic              sel;
    logic [BYTE_W-1:0] byte_q, byte_d;

    always_comb begin
      sel    = wr_en && (wr_addr == ADDR_W'(g));
      byte_d = sel ? wr_byte : byte_q;
    end

    always_ff @(posedge sclk or negedge arst_n) begin
      if (!arst_n) begin
        byte_q <= '0;
      end else begin
        byte_q <= byte_d;
      end
    end

    assign shadow_word[g*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/fr_commit_sync.sv
`timescale 1ns/1ps
module fr_commit_sync #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_async,
  input  logic              txn_wr,
  input  logic [WORD_W-1:0] shadow_word,
  output logic              commit_pulse,
  output logic [WORD_W-1:0] active_word
);
  logic              cs_meta_q, cs_sync_q, cs_prev_q;
  logic              commit_d;
  logic [WORD_W-1:0] active_d;

  always_comb begin
    commit_d = cs_sync_q && !cs_prev_q && txn_wr;
    active_d = commit_d ? shadow_word : active_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_meta_q    <= 1'b1;
      cs_sync_q    <= 1'b1;
      cs_prev_q    <= 1'b1;
      commit_pulse <= 1'b0;
      active_word  <= '0;
    end else begin
      cs_meta_q    <= cs_n_async;
      cs_sync_q    <= cs_meta_q;
      cs_prev_q    <= cs_sync_q;
      commit_pulse <= commit_d;
      active_word  <= active_d;
    end
  end
endmodule

// File: rtl/fr_phase_acc.sv
`timescale 1ns/1ps
module fr_phase_acc #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned OUT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] inc,
  output logic [OUT_W-1:0]  phase_out
);
  logic [WORD_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_out = phase_q[WORD_W-1 -: OUT_W];
endmodule

// File: rtl/fr_tune_port.sv
`timescale 1ns/1ps
module fr_tune_port
  import fr_tune_pkg::*;
#(
  parameter int unsigned OUT_W = PHASE_OUT_W
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              fr_sclk,
  input  logic              fr_cs_n,
  input  logic [NIB_W-1:0]  fr_data,
  output logic              commit_pulse,
  output logic [WORD_W-1:0] freq_word,
  output logic [OUT_W-1:0]  phase_out
);
  logic              xfer_rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_byte;
  logic              txn_wr;
  logic [WORD_W-1:0] shadow_word;

  assign xfer_rst_n = sys_rst_n & ~fr_cs_n;

  fr_serial_rx #(.NIB_W(NIB_W), .HDR_NIBS(HDR_NIBS)) u_rx (
    .sclk       (fr_sclk),
    .xfer_rst_n (xfer_rst_n),
    .arst_n     (sys_rst_n),
    .nib_in     (fr_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_byte    (wr_byte),
    .txn_wr     (txn_wr)
  );

  fr_shadow_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_shadow (
    .sclk        (fr_sclk),
    .arst_n      (sys_rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_byte     (wr_byte),
    .shadow_word (shadow_word)
  );

  fr_commit_sync #(.WORD_W(WORD_W)) u_commit (
    .clk          (sys_clk),
    .rst_n        (sys_rst_n),
    .cs_n_async   (fr_cs_n),
    .txn_wr       (txn_wr),
    .shadow_word  (shadow_word),
    .commit_pulse (commit_pulse),
    .active_word  (freq_word)
  );

  fr_phase_acc #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_acc (
    .clk       (sys_clk),
    .rst_n     (sys_rst_n),
    .inc       (freq_word),
    .phase_out (phase_out)
  );
endmodule

// File: rtl/fr_tune_port_chk.sv
`timescale 1ns/1ps
module fr_tune_port_chk #(
  parameter int unsigned WORD_W = 64
) (
  input logic              sys_clk,
  input logic              sys_rst_n,
  input logic              fr_cs_n,
  input logic              commit_pulse,
  input logic              txn_wr,
  input logic [WORD_W-1:0] freq_word,
  input logic [WORD_W-1:0] phase_q
);
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    commit_pulse |=> !commit_pulse); // R5
  AST_WORD_ONLY_ON_COMMIT: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !$stable(freq_word) |-> commit_pulse); // R5
  AST_COMMIT_AFTER_RELEASE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    commit_pulse |-> fr_cs_n); // R5
  AST_NO_COMMIT_ON_READ: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    commit_pulse |-> txn_wr); // R6
  AST_PHASE_STEP: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $past(sys_rst_n) |-> (phase_q == $past(phase_q) + $past(freq_word))); // R8
endmodule

bind fr_tune_port fr_tune_port_chk #(.WORD_W(fr_tune_pkg::WORD_W)) u_chk (
  .sys_clk      (sys_clk),
  .sys_rst_n    (sys_rst_n),
  .fr_cs_n      (fr_cs_n),
  .commit_pulse (commit_pulse),
  .txn_wr       (txn_wr),
  .freq_word    (freq_word),
  .phase_q      (u_acc.phase_q)
);

// File: tb/fr_tune_port_tb.sv
`timescale 1ns/1ps
module fr_tune_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic [3:0]  sdata = '0;
  logic        commit_pulse;
  logic [63:0] freq_word;
  logic [15:0] phase_out;

  int n_checks = 0;
  int n_fail   = 0;
  int n_commits = 0;
  bit done = 1'b0;
  bit prev_commit = 1'b0;

  logic [7:0]  exp_sh [0:7];
  logic [7:0]  pay [0:15];
  logic [63:0] last_word = '0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  fr_tune_port dut_i (
    .sys_clk      (clk),
    .sys_rst_n    (rst_n),
    .fr_sclk      (sclk),
    .fr_cs_n      (cs_n),
    .fr_data      (sdata),
    .commit_pulse (commit_pulse),
    .freq_word    (freq_word),
    .phase_out    (phase_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_word();
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[i*8 +: 8] = exp_sh[i];
    return w;
  endfunction

  // monitor: pops expected words as commits appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (commit_pulse && prev_commit)
        chk(1'b0, "R5 pulse wider than one cycle", 64'd1, 64'd0);
      if (commit_pulse && !prev_commit) begin
        n_commits++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected commit", freq_word, last_word);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(freq_word == e, t, freq_word, e);
          last_word = e;
        end
      end
      prev_commit = commit_pulse;
    end
  end

  task automatic send_nib(input logic [3:0] n);
    sdata = n;
    #10 sclk = 1'b1;
    #10 sclk = 1'b0;
  endtask

  task automatic run_txn(input bit rd, input logic [14:0] addr, input int nbytes,
                         input bit half, input string tag);
    logic [14:0] a;
    cs_n = 1'b0;
    #10;
    send_nib({rd, addr[14:12]});
    send_nib(addr[11:8]);
    send_nib(addr[7:4]);
    send_nib(addr[3:0]);
    a = addr;
    for (int i = 0; i < nbytes; i++) begin
      send_nib(pay[i][7:4]);
      send_nib(pay[i][3:0]);
      if (!rd && a < 15'd8) exp_sh[a[2:0]] = pay[i];
      a = a + 15'd1;
    end
    if (half) send_nib(4'hA);
    @(negedge clk);
    chk(freq_word == last_word, "R5 word held while selected", freq_word, last_word);
    if (!rd) begin
      exp_q.push_back(model_word());
      tag_q.push_back(tag);
    end
    #10 cs_n = 1'b1;
    repeat (12) @(posedge clk);
  endtask

  task automatic phase_step(input logic [15:0] k);
    logic [15:0] p0, p1;
    @(negedge clk) p0 = phase_out;
    @(negedge clk) p1 = phase_out;
    chk(16'(p1 - p0) == k, "R8 phase step", 64'(16'(p1 - p0)), 64'(k));
  endtask

  initial begin
    int c0;
    for (int i = 0; i < 8; i++) exp_sh[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(freq_word == 64'd0, "R9 word at reset", freq_word, 64'd0);
    chk(phase_out == 16'd0, "R9 phase at reset", 64'(phase_out), 64'd0);
    chk(commit_pulse == 1'b0, "R9 commit at reset", 64'(commit_pulse), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R3 full 64-bit word in 20 serial clocks, R2 byte order
    for (int i = 0; i < 8; i++) pay[i] = 8'h11 * 8'(i + 1) + 8'h0F;
    run_txn(1'b0, 15'd0, 8, 1'b0, "R3 full word R2 byte order");

    // R10 partial update keeps other bytes, R1 start address
    pay[0] = 8'hC3; pay[1] = 8'h5A;
    run_txn(1'b0, 15'd3, 2, 1'b0, "R10 partial update R1 address");

    // R4 trailing half byte discarded
    pay[0] = 8'h77;
    run_txn(1'b0, 15'd1, 1, 1'b1, "R4 half byte dropped");

    // R7 increment runs past address 7
    pay[0] = 8'hE1; pay[1] = 8'hE2; pay[2] = 8'hE3; pay[3] = 8'hE4;
    run_txn(1'b0, 15'd6, 4, 1'b0, "R7 overflow addresses ignored");

    // R7 high address bits set: header-only effect
    pay[0] = 8'h99; pay[1] = 8'h98;
    run_txn(1'b0, 15'h4000, 2, 1'b0, "R7 far address ignored");

    // R6 read transaction: no commit, no shadow change
    c0 = n_commits;
    pay[0] = 8'hAB; pay[1] = 8'hCD;
    run_txn(1'b1, 15'd0, 2, 1'b0, "R6 read");
    chk(n_commits == c0, "R6 read made no commit", 64'(n_commits), 64'(c0));
    run_txn(1'b0, 15'd0, 0, 1'b0, "R6 shadow untouched by read");

    // R8 phase stepping and wrap
    for (int i = 0; i < 8; i++) pay[i] = 8'h00;
    pay[6] = 8'h03;
    run_txn(1'b0, 15'd0, 8, 1'b0, "R8 load step 3");
    phase_step(16'd3);
    phase_step(16'd3);
    pay[6] = 8'hFF; pay[7] = 8'hFF;
    run_txn(1'b0, 15'd0, 8, 1'b0, "R8 load step ffff");
    phase_step(16'hFFFF);

    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R5 every write committed", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule